// File: doc/BRIEF.md
# Five-Channel Prescaled Down-Counting Timer

This block is a timer peripheral with five independent 32-bit down-counters behind a small word-addressed register interface. Two shared 8-bit prescalers each produce a base tick. Channels 0 and 1 take their tick from the first prescaler, and channels 2 to 4 take it from the second. Each channel then divides its base tick by 1, 2, 4, 8 or 16. Every channel has a count buffer and a compare buffer. Software copies these buffers into the live counter by holding the channel's update bit. It then starts the channel with a second write to the control register.

A channel counts down once per divided tick. An expiry occurs when the counter steps from 1 to 0. In one-shot mode the counter then stays at zero. In periodic mode the counter reloads from the count buffer on the following tick. Each expiry sets a per-channel status flag. Software clears the flag by writing a 1 to it. The interrupt line of a channel is its status flag gated by its enable. Each channel also drives an output level derived from the counter and the compare value, with an optional inversion.

Top module: `ptmr_top`

## Requirements
- R1: Registers read back at these byte offsets:
  - prescaler config at 0x00, where bits [7:0] are prescaler 0 and bits [15:8] are prescaler 1.
  - divider config at 0x04, where bits [4n+3:4n] are the divider code of channel n.
  - control at 0x08.
  - interrupt register at 0x44.
  - count buffer of channel n at 0x0C+12n.
  - compare buffer of channel n (n<4) at 0x10+12n.

  Unused bits read 0.
- R2: Each channel has a 4-bit control group. Bit 0 is start, bit 1 is update, bit 2 is invert and bit 3 is auto-reload. Channel 0 uses control bits [3:0] and channel k>0 uses bits [4k+7:4k+4]. Bits [7:4] and [31:24] are not stored and read 0.
- R3: While update is set, the counter and compare register of the channel take the buffer values on every clock, and the counter does not count. The live counter reads at 0x14+12n for n<4 and at 0x40 for channel 4.
- R4: A channel with start set and update clear decrements once every (P+1)·2^D clocks. P is its group's prescaler field and D is its divider code, with codes above 4 acting as 4. The prescaler counters run freely from reset.
- R5: In one-shot mode (auto-reload clear), the step from 1 to 0 sets the channel's status flag once. The counter then stays at 0.
- R6: In periodic mode (auto-reload set), a tick that finds the counter at 0 reloads the count buffer and the compare buffer. An expiry then repeats every buffer+1 ticks.
- R7: A count buffer value of 1 produces an expiry. A value of 0 produces none.
- R8: In the interrupt register, bits [4:0] are the channel enables and bits [9:5] are the status flags of channels 0 to 4. Writing 1 to a status bit clears it, but an expiry in the same cycle wins. irq_o[n] is status n AND enable n.
- R9: Clearing start freezes the counter at its current value.
- R10: tout_o[n] is high when the counter is nonzero and not above the compare register, XOR the invert bit. Channel 4 has no compare buffer, so its compare value is 0.
- R11: After reset, every register, counter, status flag, irq_o and tout_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 5 | Per-channel interrupt |
| tout_o | output | 5 | Per-channel output level |

## Verification
The in-RTL assertions check several rules on every clock:
- that update loads the count buffer;
- that a stopped channel holds its value;
- that an expiry lands the counter on 0;
- that periodic mode reloads and one-shot mode stays at 0;
- that a status flag sets after an expiry and clears after a write-1.

Only the bench scenarios can show the actual tick spacing for a given prescaler and divider, including the clamp of large divider codes. They also show the register layout and the skipped control slot, and the zero-versus-one buffer corner. A behavioural reference model checks irq_o and tout_o every cycle against these scenarios.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int NCH  = 5;   // channels
    localparam int NGRP = 2;   // shared prescalers
    localparam int DW   = 32;  // bus data width
    localparam int AW   = 8;   // bus address width
    localparam int CW   = DW;  // counter width
    localparam int PW   = 8;   // prescaler field width
    localparam int DSW  = 4;   // divider code / divider counter width
    localparam int DMAX = 4;   // largest log2 divisor
    localparam int GRPW = 4;   // control bits per channel

    localparam logic [AW-1:0] A_PRE = 8'h00;
    localparam logic [AW-1:0] A_DIV = 8'h04;
    localparam logic [AW-1:0] A_CTL = 8'h08;
    localparam logic [AW-1:0] A_INT = 8'h44;
    localparam logic [AW-1:0] A_OBS_LAST = 8'h40;

    // bit 0 start, bit 1 update, bit 2 invert, bit 3 auto-reload
    typedef struct packed {
        logic arl;
        logic inv;
        logic upd;
        logic start;
    } chctl_t;

    // control group slot: channel 0 at 0, channel k at k+1 (R2)
    function automatic int ctl_lsb(int ch);
        return (ch == 0) ? 0 : GRPW * (ch + 1);
    endfunction

    function automatic int grp_of(int ch);
        return (ch < 2) ? 0 : 1;
    endfunction

    function automatic logic [AW-1:0] cbuf_addr(int ch);
        return AW'(12 + 12 * ch);
    endfunction

    function automatic logic [AW-1:0] cmpb_addr(int ch);
        return AW'(16 + 12 * ch);
    endfunction

    function automatic logic [AW-1:0] obs_addr(int ch);
        return (ch == NCH - 1) ? A_OBS_LAST : AW'(20 + 12 * ch);
    endfunction

    // low-bit mask of the divider counter for a code, codes above DMAX clamp
    function automatic logic [DSW-1:0] div_mask(logic [DSW-1:0] code);
        int d;
        d = (int'(code) > DMAX) ? DMAX : int'(code);
        return DSW'((1 << d) - 1);
    endfunction
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
    import ptmr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_i,
    input  logic [AW-1:0]               addr_i,
    input  logic [DW-1:0]               wdata_i,
    output logic [DW-1:0]               rdata_o,
    input  logic [NCH-1:0]              exp_i,
    input  logic [NCH-1:0][CW-1:0]      obs_i,
    output logic [NGRP-1:0][PW-1:0]     pre_o,
    output logic [NCH-1:0][DSW-1:0]     div_o,
    output chctl_t [NCH-1:0]            ctl_o,
    output logic [NCH-1:0][CW-1:0]      cbuf_o,
    output logic [NCH-1:0][CW-1:0]      cmpb_o,
    output logic [NCH-1:0]              irq_o
);
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] st_q;
    logic [NCH-1:0] st_clr;
    logic           wr_pre, wr_div, wr_ctl, wr_int;

    assign wr_pre = wr_i && (addr_i == A_PRE);
    assign wr_div = wr_i && (addr_i == A_DIV);
    assign wr_ctl = wr_i && (addr_i == A_CTL);
    assign wr_int = wr_i && (addr_i == A_INT);
    assign st_clr = wr_int ? wdata_i[2*NCH-1:NCH] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_o  <= '0;
            div_o  <= '0;
            ctl_o  <= '0;
            cbuf_o <= '0;
            cmpb_o <= '0;
            en_q   <= '0;
            st_q   <= '0;
        end else begin
            if (wr_pre) pre_o <= wdata_i[NGRP*PW-1:0];
            if (wr_div) div_o <= wdata_i[NCH*DSW-1:0];
            if (wr_int) en_q  <= wdata_i[NCH-1:0];
            for (int ch = 0; ch < NCH; ch++) begin
                if (wr_ctl)
                    ctl_o[ch] <= chctl_t'(wdata_i[ctl_lsb(ch) +: GRPW]);
                if (wr_i && addr_i == cbuf_addr(ch))
                    cbuf_o[ch] <= wdata_i;
                if (ch < NCH - 1 && wr_i && addr_i == cmpb_addr(ch))
                    cmpb_o[ch] <= wdata_i;
            end
            // expiry wins over a same-cycle clear (R8)
            st_q <= (st_q & ~st_clr) | exp_i;
        end
    end

    assign irq_o = st_q & en_q;

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_PRE) rdata_o[NGRP*PW-1:0] = pre_o;
        if (addr_i == A_DIV) rdata_o[NCH*DSW-1:0] = div_o;
        if (addr_i == A_CTL)
            for (int ch = 0; ch < NCH; ch++)
                rdata_o[ctl_lsb(ch) +: GRPW] = ctl_o[ch];
        if (addr_i == A_INT) rdata_o[2*NCH-1:0] = {st_q, en_q};
        for (int ch = 0; ch < NCH; ch++) begin
            if (addr_i == cbuf_addr(ch)) rdata_o = cbuf_o[ch];
            if (ch < NCH - 1 && addr_i == cmpb_addr(ch)) rdata_o = cmpb_o[ch];
            if (addr_i == obs_addr(ch)) rdata_o = obs_i[ch];
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        // R8: an expiry leaves the status flag set on the next cycle
        a_r8_status_sets: assert property (@(posedge clk) disable iff (rst)
            exp_i[n] |=> st_q[n])
            else $error("R8 status flag %0d did not set", n);
        // R8: write-1 clears when no expiry coincides
        a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
            (wr_int && wdata_i[NCH+n] && !exp_i[n]) |=> !st_q[n])
            else $error("R8 status flag %0d did not clear", n);
    end
endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
    import ptmr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NGRP-1:0][PW-1:0] pre_i,
    input  logic [NCH-1:0][DSW-1:0] div_i,
    output logic [NCH-1:0]          tick_o
);
    logic [NGRP-1:0][PW-1:0]  pcnt_q;
    logic [NGRP-1:0][DSW-1:0] dcnt_q;
    logic [NGRP-1:0]          pre_tick;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // >= so that lowering the field mid-count still wraps at once
        assign pre_tick[g] = (pcnt_q[g] >= pre_i[g]);

        always_ff @(posedge clk) begin
            if (rst) begin
                pcnt_q[g] <= '0;
                dcnt_q[g] <= '0;
            end else if (pre_tick[g]) begin
                pcnt_q[g] <= '0;
                dcnt_q[g] <= dcnt_q[g] + 1'b1;
            end else begin
                pcnt_q[g] <= pcnt_q[g] + 1'b1;
            end
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int G = grp_of(ch);
        logic [DSW-1:0] m;
        assign m = div_mask(div_i[ch]);
        assign tick_o[ch] = pre_tick[G] && ((dcnt_q[G] & m) == m);
    end
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
    import ptmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  chctl_t        ctl_i,
    input  logic [CW-1:0] cbuf_i,
    input  logic [CW-1:0] cmpb_i,
    output logic [CW-1:0] cnt_o,
    output logic          exp_o,
    output logic          out_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cmp_q;
    logic          run;
    logic          at_zero;

    assign run     = ctl_i.start && !ctl_i.upd && tick_i;
    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cmp_q <= '0;
        end else if (ctl_i.upd) begin
            cnt_q <= cbuf_i;
            cmp_q <= cmpb_i;
        end else if (run) begin
            if (at_zero) begin
                if (ctl_i.arl) begin
                    cnt_q <= cbuf_i;
                    cmp_q <= cmpb_i;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign exp_o = run && (cnt_q == CW'(1));
    assign out_o = (!at_zero && (cnt_q <= cmp_q)) ^ ctl_i.inv;
    assign cnt_o = cnt_q;

    // R3: update copies the count buffer
    a_r3_update_loads: assert property (@(posedge clk) disable iff (rst)
        ctl_i.upd |=> (cnt_q == $past(cbuf_i)))
        else $error("R3 update did not load counter");
    // R9: a stopped channel holds its count
    a_r9_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.start && !ctl_i.upd) |=> $stable(cnt_q))
        else $error("R9 stopped counter moved");
    // R5: an expiry lands on zero
    a_r5_expiry_to_zero: assert property (@(posedge clk) disable iff (rst)
        exp_o |=> at_zero)
        else $error("R5 counter not zero after expiry");
    // R6: periodic reload from the count buffer
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        (run && at_zero && ctl_i.arl) |=> (cnt_q == $past(cbuf_i)))
        else $error("R6 periodic reload missing");
    // R5/R7: one-shot at zero never wraps
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (run && at_zero && !ctl_i.arl) |=> at_zero)
        else $error("R7 one-shot counter wrapped");
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq_o,
    output logic [NCH-1:0] tout_o
);
    logic [NGRP-1:0][PW-1:0]  pre;
    logic [NCH-1:0][DSW-1:0]  div;
    chctl_t [NCH-1:0]         ctl;
    logic [NCH-1:0][CW-1:0]   cbuf, cmpb, cnt;
    logic [NCH-1:0]           tick, expire;

    ptmr_regs u_regs (
        .clk(clk), .rst(rst), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .exp_i(expire),
        .obs_i(cnt), .pre_o(pre), .div_o(div), .ctl_o(ctl),
        .cbuf_o(cbuf), .cmpb_o(cmpb), .irq_o(irq_o)
    );

    ptmr_prescale u_pre (
        .clk(clk), .rst(rst), .pre_i(pre), .div_i(div), .tick_o(tick)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        ptmr_channel u_ch (
            .clk(clk), .rst(rst), .tick_i(tick[ch]), .ctl_i(ctl[ch]),
            .cbuf_i(cbuf[ch]), .cmpb_i(cmpb[ch]), .cnt_o(cnt[ch]),
            .exp_o(expire[ch]), .out_o(tout_o[ch])
        );
    end
endmodule

// File: tb/ptmr_top_tb_top.sv
module ptmr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic [4:0]  irq, tout;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ptmr_top dut_i (
        .clk(clk), .rst(rst), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .tout_o(tout)
    );

    // reference model state
    logic [7:0]  m_pre [2];
    logic [7:0]  m_pc  [2];
    logic [3:0]  m_dc  [2];
    logic [3:0]  m_div [5];
    logic [3:0]  m_ctl [5];
    logic [31:0] m_cb  [5];
    logic [31:0] m_cm  [5];
    logic [31:0] m_cnt [5];
    logic [31:0] m_cmp [5];
    logic [4:0]  m_en, m_st;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] m_tout();
        logic [4:0] t;
        for (int c = 0; c < 5; c++)
            t[c] = ((m_cnt[c] != 0) && (m_cnt[c] <= m_cmp[c])) ^ m_ctl[c][2];
        return t;
    endfunction

    always @(posedge clk) begin : model
        logic [1:0] pt;
        logic [4:0] ex, clr;
        int d, g, lsb;
        if (rst) begin
            for (int i = 0; i < 2; i++) begin m_pre[i] = 0; m_pc[i] = 0; m_dc[i] = 0; end
            for (int c = 0; c < 5; c++) begin
                m_div[c] = 0; m_ctl[c] = 0; m_cb[c] = 0; m_cm[c] = 0; m_cnt[c] = 0; m_cmp[c] = 0;
            end
            m_en = 0; m_st = 0;
        end else begin
            for (int i = 0; i < 2; i++) pt[i] = (m_pc[i] >= m_pre[i]);
            ex = 0;
            for (int c = 0; c < 5; c++) begin
                logic ct;
                g = (c < 2) ? 0 : 1;
                d = (m_div[c] > 4) ? 4 : int'(m_div[c]);
                ct = pt[g] && ((int'(m_dc[g]) % (1 << d)) == ((1 << d) - 1));
                if (m_ctl[c][1]) begin
                    m_cnt[c] = m_cb[c]; m_cmp[c] = m_cm[c];
                end else if (m_ctl[c][0] && ct) begin
                    if (m_cnt[c] == 0) begin
                        if (m_ctl[c][3]) begin m_cnt[c] = m_cb[c]; m_cmp[c] = m_cm[c]; end
                    end else begin
                        if (m_cnt[c] == 1) ex[c] = 1'b1;
                        m_cnt[c] = m_cnt[c] - 1;
                    end
                end
            end
            for (int i = 0; i < 2; i++) begin
                if (pt[i]) begin m_pc[i] = 0; m_dc[i] = m_dc[i] + 4'd1; end
                else m_pc[i] = m_pc[i] + 8'd1;
            end
            clr = (wr && addr == 8'h44) ? wdata[9:5] : 5'd0;
            m_st = (m_st & ~clr) | ex;
            if (wr) begin
                if (addr == 8'h00) begin m_pre[0] = wdata[7:0]; m_pre[1] = wdata[15:8]; end
                if (addr == 8'h44) m_en = wdata[4:0];
                for (int c = 0; c < 5; c++) begin
                    lsb = (c == 0) ? 0 : 4 * (c + 1);
                    if (addr == 8'h04) m_div[c] = wdata[4*c +: 4];
                    if (addr == 8'h08) m_ctl[c] = wdata[lsb +: 4];
                    if (addr == 8'(12 + 12 * c)) m_cb[c] = wdata;
                    if (c < 4 && addr == 8'(16 + 12 * c)) m_cm[c] = wdata;
                end
            end
        end
        #2;
        chk("R8 irq per cycle", {27'd0, irq}, {27'd0, m_st & m_en});
        chk("R10 tout per cycle", {27'd0, tout}, {27'd0, m_tout()});
    end

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; #1; v = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // read a counter every cycle, compare with the model and check tick spacing
    task automatic track(input string tag, input logic [7:0] a, input int ch,
                         input int n, input int period);
        logic [31:0] v, prev;
        int last = -1;
        rd(a, prev);
        for (int i = 0; i < n; i++) begin
            rd(a, v);
            chk({tag, " count"}, v, m_cnt[ch]);
            if (v != prev) begin
                if (last >= 0) chk({tag, " tick spacing"}, 32'(i - last), 32'(period));
                last = i;
            end
            prev = v;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] v, v2;
        int zeros;
        wait_cyc(3);
        rst = 1'b0;

        // R11 reset state
        rd(8'h00, v); chk("R11 prescaler reg", v, 0);
        rd(8'h04, v); chk("R11 divider reg", v, 0);
        rd(8'h08, v); chk("R11 control reg", v, 0);
        rd(8'h44, v); chk("R11 interrupt reg", v, 0);
        rd(8'h14, v); chk("R11 counter 0", v, 0);
        chk("R11 irq", {27'd0, irq}, 0);
        chk("R11 tout", {27'd0, tout}, 0);

        // R1 / R2 layout
        wreg(8'h00, 32'hDEAD_BE01); rd(8'h00, v); chk("R1 prescaler fields", v, 32'h0000_BE01);
        wreg(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R1 divider fields", v, 32'h000F_FFFF);
        wreg(8'h0C, 32'h1234_5678); rd(8'h0C, v); chk("R1 count buffer 0", v, 32'h1234_5678);
        wreg(8'h10, 32'h0000_A5A5); rd(8'h10, v); chk("R1 compare buffer 0", v, 32'h0000_A5A5);
        wreg(8'h3C, 32'd7);         rd(8'h3C, v); chk("R1 count buffer 4", v, 32'd7);
        wreg(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); chk("R2 control skipped slot", v, 32'h00FF_FF0F);
        // R3 update loads counters
        rd(8'h14, v); chk("R3 counter 0 loaded", v, 32'h1234_5678);
        rd(8'h40, v); chk("R3 counter 4 at 0x40", v, 32'd7);
        wreg(8'h08, 32'h0);
        wreg(8'h44, 32'hFFFF_FFFF); rd(8'h44, v); chk("R8 enables, status cleared", v, 32'h0000_001F);
        wreg(8'h44, 32'h0);

        // R4 / R5 one-shot on channel 0: (1+1)*2 = 4 clocks per tick
        wreg(8'h00, 32'h0000_0001);
        wreg(8'h04, 32'h0000_0001);
        wreg(8'h0C, 32'd3);
        wreg(8'h10, 32'd1);
        wreg(8'h44, 32'h0000_0001);
        wreg(8'h08, 32'h0000_0002);
        wreg(8'h08, 32'h0000_0001);
        track("R4 ch0", 8'h14, 0, 30, 4);
        rd(8'h14, v); chk("R5 one-shot ends at 0", v, 0);
        rd(8'h44, v); chk("R5 status 0 set", v, 32'h0000_0021);
        chk("R8 irq 0 asserted", {31'd0, irq[0]}, 1);
        wreg(8'h44, 32'h0000_0021); rd(8'h44, v); chk("R8 write-1 clear", v, 32'h0000_0001);
        wait_cyc(20);
        rd(8'h44, v); chk("R5 no second expiry", v, 32'h0000_0001);
        wreg(8'h08, 32'h0);

        // R6 periodic on channel 2, tick every clock, buffer 2 -> period 3
        wreg(8'h00, 32'h0000_0001);
        wreg(8'h24, 32'd2);
        wreg(8'h44, 32'h0000_0004);
        wreg(8'h08, 32'h0000_2000);
        wreg(8'h08, 32'h0000_9000);
        zeros = 0;
        for (int i = 0; i < 30; i++) begin
            rd(8'h2C, v);
            chk("R6 ch2 count", v, m_cnt[2]);
            if (v == 0) zeros++;
        end
        chk("R6 zero every 3rd cycle", 32'(zeros), 32'd10);
        rd(8'h44, v); chk("R6 status 2 set", {31'd0, v[7]}, 1);
        wreg(8'h08, 32'h0);
        wreg(8'h44, 32'h0000_03E0);

        // R7 buffer 1 vs 0 on channel 3
        wreg(8'h30, 32'd1);
        wreg(8'h08, 32'h0002_0000);
        wreg(8'h08, 32'h0001_0000);
        wait_cyc(5);
        rd(8'h44, v); chk("R7 buffer 1 expires", {31'd0, v[8]}, 1);
        wreg(8'h44, 32'h0000_0100);
        wreg(8'h30, 32'd0);
        wreg(8'h08, 32'h0002_0000);
        wreg(8'h08, 32'h0001_0000);
        wait_cyc(10);
        rd(8'h44, v); chk("R7 buffer 0 no expiry", {31'd0, v[8]}, 0);
        wreg(8'h08, 32'h0);

        // R9 freeze and R10 output on channel 1
        wreg(8'h18, 32'd100);
        wreg(8'h1C, 32'd200);
        wreg(8'h08, 32'h0000_0200);
        wreg(8'h08, 32'h0000_0100);
        wait_cyc(10);
        wreg(8'h08, 32'h0);
        rd(8'h20, v);
        wait_cyc(10);
        rd(8'h20, v2);
        chk("R9 frozen value held", v2, v);
        chk("R9 counter moved before stop", {31'd0, (v < 32'd100)}, 1);
        chk("R10 tout 1 high", {31'd0, tout[1]}, 1);
        wreg(8'h08, 32'h0000_0400);
        chk("R10 tout 1 inverted", {31'd0, tout[1]}, 0);
        wreg(8'h08, 32'h0);

        // R4 divider code 7 clamps to 16 on channel 4, prescaler 1 = 0
        wreg(8'h04, 32'h0007_0000);
        wreg(8'h3C, 32'd50);
        wreg(8'h08, 32'h0020_0000);
        wreg(8'h08, 32'h0010_0000);
        track("R4 ch4 clamp", 8'h40, 4, 60, 16);
        wreg(8'h08, 32'h0);

        wait_cyc(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule